// File: doc/BRIEF.md
# Page Translation Unit with Context-Tagged Cache

The unit converts virtual addresses into physical addresses for instruction fetch, load and store requests. Pages are 4 KiB. The twelve low address bits are the page offset and are passed through unchanged. The upper bits form the virtual page number (VPN). A request first probes a sixteen-entry fully associative translation cache. Each cache entry is tagged with a process context number, so a context switch needs no flush. On a miss the unit reads one 32-bit page table entry (PTE) from a single-level table, installs the entry if it is valid, and then answers the request.

Every response carries a fault code. A non-resident page gives a page fault. An access that the page's rights forbid gives a protection fault. A successful translation gives the physical page number (PPN) joined to the offset. The page table base address is an input, so software can switch tables together with the context number.

The controller has three states:
- `ST_IDLE` accepts requests and answers hits.
- `ST_FETCH` drives the one-cycle table read.
- `ST_WAIT` waits for the table data.

The transitions are:
- IDLE→FETCH on an accepted miss.
- IDLE→IDLE on a hit or when no request is accepted.
- FETCH→WAIT unconditionally.
- WAIT→IDLE when the table data arrives.
- WAIT→WAIT otherwise.

Top module: `xlat_unit`

## Requirements
- R1: On a response without fault, `rsp_paddr[11:0]` equals bits 11:0 of the request address.
- R2: An accepted request that misses causes exactly one table read. The read is a one-cycle `pt_rd_valid` pulse in the cycle after acceptance, at address `pt_base + VPN*4`. A request that hits causes no table read.
- R3: The PTE layout is: bit 31 is the valid bit, bits 30:29 hold the rights, and bits 15:0 hold the PPN. A PTE with bit 31 equal to 0 gives fault code 1 (page fault) with `rsp_paddr` equal to 0. Such a PTE is never cached, so a repeat of the same request reads the table again.
- R4: Rights bit 29 permits stores and rights bit 30 permits fetches; loads are always permitted. Request kinds are encoded as 0 = fetch, 1 = load and 2 = store. A store with bit 29 clear, or a fetch with bit 30 clear, gives fault code 2 (protection fault) with `rsp_paddr` equal to 0. The same check applies to cached entries.
- R5: With fault code 0, `rsp_paddr` equals the PPN concatenated with the page offset.
- R6: A hit produces `rsp_valid` in the cycle after acceptance.
- R7: A cache entry hits only when both its context tag and its VPN match the request. Entries of different contexts coexist in the cache.
- R8: A refill uses the lowest-numbered empty entry. When no entry is empty, it uses a round-robin pointer; the pointer starts at entry 0 after reset or flush and advances on each such replacement.
- R9: A one-cycle `flush` empties every entry, so the next request to any page misses.
- R10: After reset, `req_ready` is 1 while `rsp_valid` and `pt_rd_valid` are 0. `req_ready` is low from acceptance of a miss until the cycle after the table data returns. The response appears in the cycle after `pt_rd_data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all translation-cache entries |
| ctx | input | CTX_W | Current process context number |
| pt_base | input | PA_W | Page table base address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| pt_rd_valid | output | 1 | Table read pulse |
| pt_rd_addr | output | PA_W | Table entry address |
| pt_rd_data_valid | input | 1 | Table data present |
| pt_rd_data | input | 32 | Page table entry |

## Verification
The bench builds the unit with its default values: 32-bit virtual addresses, 28-bit physical addresses, a 4-bit context and 16 entries. Its page table is a formula that sets the valid bit, the rights and the PPN from the word index of each entry. This lets every access kind be swept against every rights combination on both cached and freshly fetched entries, in two contexts and two tables. The sixteen-entry cache is small enough to fill and overflow, which brings the empty-slot choice and the round-robin eviction order within reach. The bench also exercises the highest VPN, flush, and page faults.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int PAGE_BITS      = 12;
    localparam int PTE_W          = 32;
    localparam int PTE_VALID_BIT  = 31;
    localparam int PTE_RIGHTS_LSB = 29;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2,
        FLT_RSVD = 2'd3
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xlat_state_t;
endpackage

// File: rtl/xlat_tcache.sv
module xlat_tcache #(
    parameter int ENTRIES = 16,
    parameter int CTX_W   = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CTX_W-1:0] lk_ctx,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [1:0]       lk_rights,
    input  logic             ins_en,
    input  logic [CTX_W-1:0] ins_ctx,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [1:0]       ins_rights
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_v;
    logic [CTX_W-1:0]   ent_ctx    [ENTRIES];
    logic [VPN_W-1:0]   ent_vpn    [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn    [ENTRIES];
    logic [1:0]         ent_rights [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   victim;
    logic               all_full;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = ent_v[g] && (ent_ctx[g] == lk_ctx) && (ent_vpn[g] == lk_vpn);
    end

    assign lk_hit   = |match;
    assign all_full = &ent_v;

    always_comb begin
        lk_ppn    = '0;
        lk_rights = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_ppn    = lk_ppn | ent_ppn[i];
                lk_rights = lk_rights | ent_rights[i];
            end
        end
    end

    always_comb begin
        victim = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_v[i]) victim = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else if (ins_en) begin
            ent_v[victim] <= 1'b1;
            if (all_full)
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            ent_ctx[victim]    <= ins_ctx;
            ent_vpn[victim]    <= ins_vpn;
            ent_ppn[victim]    <= ins_ppn;
            ent_rights[victim] <= ins_rights;
        end
    end

    // R7: context and page tags never match two entries at once
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9: the cycle after a flush nothing can hit
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
#(
    parameter int PA_W  = 28,
    parameter int PPN_W = 16
) (
    input  acc_kind_t            kind,
    input  logic [PAGE_BITS-1:0] offset,
    input  logic                 pte_valid,
    input  logic [1:0]           rights,
    input  logic [PPN_W-1:0]     ppn,
    output fault_t               fault,
    output logic [PA_W-1:0]      paddr
);
    logic deny;

    assign deny = ((kind == ACC_STORE) && !rights[0]) ||
                  ((kind == ACC_FETCH) && !rights[1]);

    always_comb begin
        if (!pte_valid)  fault = FLT_PAGE;
        else if (deny)   fault = FLT_PROT;
        else             fault = FLT_NONE;
        paddr = (fault == FLT_NONE) ? {ppn, offset} : '0;
    end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 28,
    parameter int CTX_W   = 4,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CTX_W-1:0] ctx,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             pt_rd_valid,
    output logic [PA_W-1:0]  pt_rd_addr,
    input  logic             pt_rd_data_valid,
    input  logic [PTE_W-1:0] pt_rd_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    xlat_state_t state, state_nx;

    logic [VA_W-1:0]  q_vaddr;
    logic [CTX_W-1:0] q_ctx;
    acc_kind_t        q_kind;
    logic             accept;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic [1:0]       lk_rights;
    logic             ins_en;

    acc_kind_t            c_kind;
    logic [PAGE_BITS-1:0] c_off;
    logic                 c_valid;
    logic [1:0]           c_rights;
    logic [PPN_W-1:0]     c_ppn;
    fault_t               c_fault;
    logic [PA_W-1:0]      c_paddr;

    assign req_ready = (state == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign ins_en    = (state == ST_WAIT) && pt_rd_data_valid && pt_rd_data[PTE_VALID_BIT];

    xlat_tcache #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_ctx     (ctx),
        .lk_vpn     (req_vaddr[VA_W-1:PAGE_BITS]),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn),
        .lk_rights  (lk_rights),
        .ins_en     (ins_en),
        .ins_ctx    (q_ctx),
        .ins_vpn    (q_vaddr[VA_W-1:PAGE_BITS]),
        .ins_ppn    (pt_rd_data[PPN_W-1:0]),
        .ins_rights (pt_rd_data[PTE_RIGHTS_LSB+1:PTE_RIGHTS_LSB])
    );

    always_comb begin
        if (state == ST_IDLE) begin
            c_kind   = acc_kind_t'(req_kind);
            c_off    = req_vaddr[PAGE_BITS-1:0];
            c_valid  = 1'b1;
            c_rights = lk_rights;
            c_ppn    = lk_ppn;
        end else begin
            c_kind   = q_kind;
            c_off    = q_vaddr[PAGE_BITS-1:0];
            c_valid  = pt_rd_data[PTE_VALID_BIT];
            c_rights = pt_rd_data[PTE_RIGHTS_LSB+1:PTE_RIGHTS_LSB];
            c_ppn    = pt_rd_data[PPN_W-1:0];
        end
    end

    xlat_perm #(.PA_W(PA_W), .PPN_W(PPN_W)) u_perm (
        .kind      (c_kind),
        .offset    (c_off),
        .pte_valid (c_valid),
        .rights    (c_rights),
        .ppn       (c_ppn),
        .fault     (c_fault),
        .paddr     (c_paddr)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && !lk_hit) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_WAIT;
            ST_WAIT:  if (pt_rd_data_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign pt_rd_valid = (state == ST_FETCH);
    assign pt_rd_addr  = pt_base + PA_W'({q_vaddr[VA_W-1:PAGE_BITS], 2'b00});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
            q_vaddr   <= '0;
            q_ctx     <= '0;
            q_kind    <= ACC_LOAD;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                q_vaddr <= req_vaddr;
                q_ctx   <= ctx;
                q_kind  <= acc_kind_t'(req_kind);
            end
            if ((accept && lk_hit) || ((state == ST_WAIT) && pt_rd_data_valid)) begin
                rsp_valid <= 1'b1;
                rsp_paddr <= c_paddr;
                rsp_fault <= c_fault;
            end
        end
    end

    // R10: no request is taken while a table read is outstanding
    p_busy_during_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_valid |-> !req_ready);

    // R6: a hit answers next cycle without touching the table
    p_hit_next_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (rsp_valid && !pt_rd_valid));

    // R2: a miss issues its table read the next cycle
    p_miss_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (pt_rd_valid && !rsp_valid));

    // R1: the page offset survives translation
    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[PAGE_BITS-1:0] == q_vaddr[PAGE_BITS-1:0]));

    // R3: faulting responses carry a zero address
    p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
endmodule

// File: tb/xlat_unit_test.sv
`timescale 1ns/1ps
module xlat_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [3:0]  ctx = '0;
    logic [27:0] pt_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [27:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        pt_rd_valid;
    logic [27:0] pt_rd_addr;
    logic        pt_rd_data_valid = 1'b0;
    logic [31:0] pt_rd_data = '0;

    int compared = 0;
    int mismatched = 0;
    int reads = 0;
    logic [27:0] last_rd_addr = '0;
    logic        pend = 1'b0;
    logic [27:0] pend_addr = '0;

    always #4 clk = ~clk;

    xlat_unit uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ctx(ctx), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .pt_rd_valid(pt_rd_valid), .pt_rd_addr(pt_rd_addr),
        .pt_rd_data_valid(pt_rd_data_valid), .pt_rd_data(pt_rd_data)
    );

    function automatic logic [31:0] pte_at(input logic [27:0] addr);
        int w;
        logic [15:0] ppn;
        logic [1:0]  rt;
        logic        v;
        w   = int'(addr >> 2);
        v   = (w % 7) != 3;
        rt  = 2'(w % 4);
        ppn = 16'((w * 37 + 5) & 16'hffff);
        return {v, rt, 13'd0, ppn};
    endfunction

    // table memory: one idle cycle, then data
    always @(negedge clk) begin
        pt_rd_data_valid <= 1'b0;
        if (pend) begin
            pt_rd_data_valid <= 1'b1;
            pt_rd_data       <= pte_at(pend_addr);
            pend             <= 1'b0;
        end
        if (pt_rd_valid) begin
            pend         <= 1'b1;
            pend_addr    <= pt_rd_addr;
            last_rd_addr <= pt_rd_addr;
            reads        <= reads + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic access(input logic [1:0] kind, input logic [3:0] c, input logic [27:0] base,
                          input logic [19:0] vpn, input logic [11:0] off, input bit exp_hit,
                          input string tag);
        logic [31:0] pte;
        logic [1:0]  ef;
        logic [27:0] ea;
        int r0, lat;
        pte = pte_at(base + {6'd0, vpn, 2'b00});
        if (!pte[31]) ef = 2'd1;
        else if ((kind == 2'd2 && !pte[29]) || (kind == 2'd0 && !pte[30])) ef = 2'd2;
        else ef = 2'd0;
        ea = (ef == 2'd0) ? {pte[15:0], off} : 28'd0;
        @(negedge clk);
        r0 = reads;
        ctx = c; pt_base = base; req_kind = kind; req_vaddr = {vpn, off}; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R4/R3 fault"}, 64'(rsp_fault), 64'(ef));
        check({tag, " R5/R1 paddr"}, 64'(rsp_paddr), 64'(ea));
        check({tag, " R2 reads"}, 64'(reads - r0), exp_hit ? 64'd0 : 64'd1);
        check({tag, exp_hit ? " R6 latency" : " R10 latency"}, 64'(lat), exp_hit ? 64'd1 : 64'd3);
        if (!exp_hit)
            check({tag, " R2 read addr"}, 64'(last_rd_addr), 64'(base + {6'd0, vpn, 2'b00}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [27:0] b0, b1;
        logic [19:0] list [17];
        int n;
        b0 = 28'h0100000;
        b1 = 28'h0200000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset ready", 64'(req_ready), 64'd1);
        check("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R10 reset read", 64'(pt_rd_valid), 64'd0);

        // R4 sweep: every kind on each page, first fetch refills, later kinds hit
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] p;
                p = pte_at(b0 + 28'(v * 4));
                access(2'(k), 4'd0, b0, 20'(v), 12'((v * 12'h135 + k * 12'h41) & 12'hfff),
                       (k != 0) && p[31], "R4 ctx0");
            end
        end
        // R7: other context, same virtual pages, own table
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] p;
                p = pte_at(b1 + 28'(v * 4));
                access(2'(k), 4'd1, b1, 20'(v), 12'((v * 12'h2a7 + k) & 12'hfff),
                       (k != 0) && p[31], "R7 ctx1");
            end
        end
        access(2'd1, 4'd0, b0, 20'd0, 12'h123, 1'b1, "R7 ctx0 kept");
        // R3: non-resident page is not cached
        access(2'd1, 4'd0, b0, 20'd2, 12'h010, 1'b0, "R3 repeat");

        // R9: flush drops cached entries
        do_flush();
        access(2'd1, 4'd0, b0, 20'd0, 12'h123, 1'b0, "R9 after flush");
        access(2'd0, 4'd0, b0, 20'hfffff, 12'hfff, 1'b0, "R2 top vpn");
        access(2'd2, 4'd0, b0, 20'hfffff, 12'h000, 1'b1, "R4 top vpn hit");

        // R8: fill, overflow, round-robin eviction
        do_flush();
        n = 0;
        for (int v = 256; v < 300 && n < 17; v++) begin
            logic [31:0] p;
            p = pte_at(b0 + 28'(v * 4));
            if (p[31]) begin
                list[n] = 20'(v);
                n++;
            end
        end
        for (int i = 0; i < 17; i++)
            access(2'd1, 4'd2, b0, list[i], 12'(i * 9), 1'b0, "R8 fill");
        access(2'd1, 4'd2, b0, list[0], 12'h0aa, 1'b0, "R8 evicted first");
        access(2'd1, 4'd2, b0, list[2], 12'h0bb, 1'b1, "R8 survivor");
        access(2'd1, 4'd2, b0, list[1], 12'h0cc, 1'b0, "R8 evicted second");
        access(2'd1, 4'd2, b0, list[16], 12'h0dd, 1'b1, "R8 newest kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule